// File: doc/BRIEF.md
# Clock Generator Configuration Slave (Two-Wire)

This block is the configuration front end of a programmable multiphase clock generator. A host reaches it over a two-wire serial bus with open-drain data. The block runs on a fast system clock and oversamples the bus clock and data lines. It drives the data line only through an active-high pull-low enable. Three registers live inside it:
- a control byte with the output divider, the spread amount, the phase mode and the spread rate,
- a 4-bit oscillator code,
- a 4-bit device register that holds a deferred-commit flag and the low three bits of the device address.

The decoded fields drive the clock generator directly.

Each register has a working copy, which drives the outputs, and a modelled nonvolatile copy. With deferred commit off, every accepted write also reaches the nonvolatile copy. With deferred commit on, only the working copy changes until a commit command arrives. While the modelled nonvolatile write runs, the block refuses to acknowledge its device address, so a host can poll until it is ready. A warm reset reloads the working copies from the nonvolatile copy. A power-on reset restores the factory values.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The device address byte, sent MSB first, is 1,0,1,1,A2,A1,A0,R/W. The block acknowledges it only when A2..A0 equal bits 2..0 of the device register (register 0Dh). Any other address gets no acknowledge, and the block stays silent until the next START.
- R2: Reads return these values:
  - register 02h returns all 8 bits;
  - registers 08h and 0Dh return their 4-bit value in bits 3..0, with bits 7..4 read as 1;
  - any other register address reads as FFh.
- R3: A read is a write of the device address and a register address, then a repeated START, then the device address with R/W = 1. The data comes back MSB first and returns the register named by the last register-address byte. A master NACK ends the read.
- R4: Bit 3 of register 0Dh is the deferred-commit flag.
  - With the flag at 0, an accepted write to 02h or 08h also updates the nonvolatile copy.
  - With the flag at 1, such a write changes only the working copy. A register-address byte of 3Fh then copies all working registers to the nonvolatile copy.
- R5: These writes are acknowledged but leave the register unchanged:
  - a write to 08h whose low nibble is 11 to 15;
  - a write to 02h whose bits 5..4 are 11.
- R6: A write to 0Dh always updates the nonvolatile copy, whatever the value of the deferred-commit flag.
- R7: After any nonvolatile update, the device address is not acknowledged for NV_BUSY_CYCLES system clocks. After that time it is acknowledged again.
- R8: Bus data is sampled on the SCL rising edge. The block changes its data-line drive only while SCL is low and never holds SCL low.
- R9: A STOP releases the data line. A START at any point, including in the middle of a byte, restarts address matching.
- R10: Power-on reset sets the nonvolatile copy to 02h = CDh, 08h = 0 and 0Dh = 0. A warm reset (rst_n) reloads every working register from the nonvolatile copy.
- R11: The bits of register 02h drive the outputs as follows:
  - bits 7..6 drive dither_rate_o;
  - bits 5..4 drive phase_mode_o;
  - bits 3..2 drive dither_amt_o;
  - bits 1..0 drive div_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| por_n | input | 1 | Power-on reset, active low; restores the factory nonvolatile values |
| rst_n | input | 1 | Warm reset, active low; reloads the working registers from the nonvolatile copy |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, pulls the data line low |
| div_sel_o | output | 2 | Output divider select (bits 1..0 of 02h) |
| dither_amt_o | output | 2 | Spread amount select (bits 3..2 of 02h) |
| phase_mode_o | output | 2 | Phase mode select (bits 5..4 of 02h) |
| dither_rate_o | output | 2 | Spread rate select (bits 7..6 of 02h) |
| osc_code_o | output | 4 | Oscillator frequency code (08h) |
| dev_addr_o | output | 3 | Programmable low device-address bits (bits 2..0 of 0Dh) |
| defer_o | output | 1 | Deferred-commit flag (bit 3 of 0Dh) |

## Verification
The write/read path is tried with a table of register and data pairs. The table includes legal values, reserved oscillator codes, the reserved phase code, set upper don't-care bits and an unmapped address, so a stored value can be told apart from a rejected one and from a masked readback. Address handling is tried with foreign addresses, a reprogrammed device address and a START in the middle of an address byte. These show whether matching uses the live register and restarts correctly. The nonvolatile side is probed two ways:
- an address attempt made straight after each kind of write, where a NACK or an ACK shows whether a nonvolatile update started;
- a warm reset, after which the outputs show what the nonvolatile copy actually holds.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int REG_W = 8;
  localparam int DAC_W = 4;
  localparam int ADR_W = 4;
  localparam int DEV_W = 3;

  localparam logic [3:0]       ADDR_HI    = 4'b1011;
  localparam logic [REG_W-1:0] RA_CTRL    = 8'h02;
  localparam logic [REG_W-1:0] RA_OSC     = 8'h08;
  localparam logic [REG_W-1:0] RA_DEV     = 8'h0D;
  localparam logic [REG_W-1:0] RA_COMMIT  = 8'h3F;

  localparam logic [REG_W-1:0] DEF_CTRL   = 8'hCD;
  localparam logic [DAC_W-1:0] DEF_OSC    = 4'h0;
  localparam logic [ADR_W-1:0] DEF_DEV    = 4'h0;

  localparam logic [DAC_W-1:0] OSC_MAX    = 4'd10;
  localparam logic [1:0]       PHASE_RSVD = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_REGPTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } eng_state_t;
endpackage

// File: rtl/clkcfg_rst_sync.sv
module clkcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  always_comb begin
    scl_s     = scl_pipe[STAGES-1];
    sda_s     = sda_pipe[STAGES-1];
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/clkcfg_bus_engine.sv
module clkcfg_bus_engine
  import clkcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [DEV_W-1:0] dev_addr,
  input  logic             nv_busy,
  input  logic [REG_W-1:0] rd_data,
  output logic             sda_oe,
  output logic [REG_W-1:0] ptr,
  output logic             wr_en,
  output logic [REG_W-1:0] wr_data,
  output logic             cmd_en,
  output logic             addr_ack
);
  eng_state_t       st, st_n;
  logic [3:0]       cnt, cnt_n;
  logic             in_ack, in_ack_n;
  logic [REG_W-1:0] sh, sh_n;
  logic             oe, oe_n;
  logic [REG_W-1:0] ptr_n;
  logic             mack, mack_n;

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    in_ack_n = in_ack;
    sh_n     = sh;
    oe_n     = oe;
    ptr_n    = ptr;
    mack_n   = mack;
    wr_en    = 1'b0;
    cmd_en   = 1'b0;
    addr_ack = 1'b0;
    if (stop_det) begin
      st_n = ST_IDLE; oe_n = 1'b0; in_ack_n = 1'b0; cnt_n = '0;
    end else if (start_det) begin
      st_n = ST_DEVADDR; oe_n = 1'b0; in_ack_n = 1'b0; cnt_n = '0;
    end else begin
      case (st)
        ST_DEVADDR, ST_REGPTR, ST_WDATA: begin
          if (scl_rise && !in_ack && cnt < 4'd8) begin
            sh_n  = {sh[REG_W-2:0], sda_s};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && !in_ack && cnt == 4'd8) begin
            in_ack_n = 1'b1;
            case (st)
              ST_DEVADDR: begin
                if (sh[7:1] == {ADDR_HI, dev_addr} && !nv_busy) begin
                  oe_n     = 1'b1;
                  addr_ack = 1'b1;
                end else begin
                  st_n     = ST_SKIP;
                  in_ack_n = 1'b0;
                end
              end
              ST_REGPTR: begin
                oe_n   = 1'b1;
                ptr_n  = sh;
                cmd_en = (sh == RA_COMMIT);
              end
              default: begin
                oe_n  = 1'b1;
                wr_en = 1'b1;
              end
            endcase
          end else if (scl_fall && in_ack) begin
            in_ack_n = 1'b0;
            cnt_n    = '0;
            oe_n     = 1'b0;
            case (st)
              ST_DEVADDR: begin
                if (sh[0]) begin
                  st_n = ST_RDATA;
                  sh_n = rd_data;
                  oe_n = ~rd_data[REG_W-1];
                end else begin
                  st_n = ST_REGPTR;
                end
              end
              ST_REGPTR: st_n = ST_WDATA;
              default:   st_n = ST_SKIP;
            endcase
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            if (in_ack) mack_n = ~sda_s;
            else        cnt_n  = cnt + 4'd1;
          end else if (scl_fall) begin
            if (in_ack) begin
              in_ack_n = 1'b0;
              cnt_n    = '0;
              if (mack) begin
                sh_n = rd_data;
                oe_n = ~rd_data[REG_W-1];
              end else begin
                oe_n = 1'b0;
                st_n = ST_SKIP;
              end
            end else if (cnt == 4'd8) begin
              oe_n     = 1'b0;
              in_ack_n = 1'b1;
            end else begin
              sh_n = {sh[REG_W-2:0], 1'b0};
              oe_n = ~sh[REG_W-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      in_ack <= 1'b0;
      sh     <= '0;
      oe     <= 1'b0;
      ptr    <= '0;
      mack   <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      in_ack <= in_ack_n;
      sh     <= sh_n;
      oe     <= oe_n;
      ptr    <= ptr_n;
      mack   <= mack_n;
    end
  end

  assign sda_oe  = oe;
  assign wr_data = sh;
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int NV_BUSY_CYCLES = 50000
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cmd_en,
  input  logic [REG_W-1:0] rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] ctrl,
  output logic [DAC_W-1:0] osc,
  output logic [ADR_W-1:0] dev,
  output logic             nv_busy
);
  localparam int BUSY_W = $clog2(NV_BUSY_CYCLES + 1);

  logic [REG_W-1:0]  nv_ctrl, nv_ctrl_n, w_ctrl, w_ctrl_n;
  logic [DAC_W-1:0]  nv_osc, nv_osc_n, w_osc, w_osc_n;
  logic [ADR_W-1:0]  nv_dev, nv_dev_n, w_dev, w_dev_n;
  logic              loaded, loaded_n;
  logic [BUSY_W-1:0] busy_cnt, busy_cnt_n;
  logic              hit_ctrl, hit_osc, hit_dev, defer, nv_wr;

  always_comb begin
    defer    = w_dev[ADR_W-1];
    hit_ctrl = wr_en && wr_addr == RA_CTRL && wr_data[5:4] != PHASE_RSVD;
    hit_osc  = wr_en && wr_addr == RA_OSC && wr_data[DAC_W-1:0] <= OSC_MAX;
    hit_dev  = wr_en && wr_addr == RA_DEV;
    nv_wr    = cmd_en | hit_dev | ((hit_ctrl | hit_osc) & ~defer);

    nv_ctrl_n = nv_ctrl;
    nv_osc_n  = nv_osc;
    nv_dev_n  = nv_dev;
    if (cmd_en) begin
      nv_ctrl_n = w_ctrl;
      nv_osc_n  = w_osc;
      nv_dev_n  = w_dev;
    end
    if (hit_ctrl && !defer) nv_ctrl_n = wr_data;
    if (hit_osc && !defer)  nv_osc_n  = wr_data[DAC_W-1:0];
    if (hit_dev)            nv_dev_n  = wr_data[ADR_W-1:0];

    loaded_n = 1'b1;
    w_ctrl_n = w_ctrl;
    w_osc_n  = w_osc;
    w_dev_n  = w_dev;
    if (!loaded) begin
      w_ctrl_n = nv_ctrl;
      w_osc_n  = nv_osc;
      w_dev_n  = nv_dev;
    end else begin
      if (hit_ctrl) w_ctrl_n = wr_data;
      if (hit_osc)  w_osc_n  = wr_data[DAC_W-1:0];
      if (hit_dev)  w_dev_n  = wr_data[ADR_W-1:0];
    end

    busy_cnt_n = busy_cnt;
    if (nv_wr)               busy_cnt_n = BUSY_W'(NV_BUSY_CYCLES);
    else if (busy_cnt != '0) busy_cnt_n = busy_cnt - BUSY_W'(1);

    case (rd_addr)
      RA_CTRL: rd_data = w_ctrl;
      RA_OSC:  rd_data = {{(REG_W-DAC_W){1'b1}}, w_osc};
      RA_DEV:  rd_data = {{(REG_W-ADR_W){1'b1}}, w_dev};
      default: rd_data = '1;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      nv_ctrl <= DEF_CTRL;
      nv_osc  <= DEF_OSC;
      nv_dev  <= DEF_DEV;
    end else begin
      nv_ctrl <= nv_ctrl_n;
      nv_osc  <= nv_osc_n;
      nv_dev  <= nv_dev_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_ctrl   <= DEF_CTRL;
      w_osc    <= DEF_OSC;
      w_dev    <= DEF_DEV;
      loaded   <= 1'b0;
      busy_cnt <= '0;
    end else begin
      w_ctrl   <= w_ctrl_n;
      w_osc    <= w_osc_n;
      w_dev    <= w_dev_n;
      loaded   <= loaded_n;
      busy_cnt <= busy_cnt_n;
    end
  end

  assign ctrl    = w_ctrl;
  assign osc     = w_osc;
  assign dev     = w_dev;
  assign nv_busy = (busy_cnt != '0);
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
  import clkcfg_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int NV_BUSY_CYCLES = 50000
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [1:0]       div_sel_o,
  output logic [1:0]       dither_amt_o,
  output logic [1:0]       phase_mode_o,
  output logic [1:0]       dither_rate_o,
  output logic [DAC_W-1:0] osc_code_o,
  output logic [DEV_W-1:0] dev_addr_o,
  output logic             defer_o
);
  logic             por_s_n, rst_w_n, rst_comb_n;
  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             nv_busy, wr_en, cmd_en, addr_ack;
  logic [REG_W-1:0] ptr, wr_data, rd_data, ctrl;
  logic [ADR_W-1:0] dev;

  assign rst_comb_n = rst_n & por_n;

  clkcfg_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_s_n)
  );

  clkcfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .arst_n(rst_comb_n), .srst_n(rst_w_n)
  );

  clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_lines (
    .clk(clk), .rst_n(rst_w_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  clkcfg_bus_engine u_engine (
    .clk(clk), .rst_n(rst_w_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .dev_addr(dev[DEV_W-1:0]), .nv_busy(nv_busy), .rd_data(rd_data),
    .sda_oe(sda_oe), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_en(cmd_en), .addr_ack(addr_ack)
  );

  clkcfg_regbank #(.NV_BUSY_CYCLES(NV_BUSY_CYCLES)) u_regs (
    .clk(clk), .por_n(por_s_n), .rst_n(rst_w_n), .wr_en(wr_en),
    .wr_addr(ptr), .wr_data(wr_data), .cmd_en(cmd_en), .rd_addr(ptr),
    .rd_data(rd_data), .ctrl(ctrl), .osc(osc_code_o), .dev(dev),
    .nv_busy(nv_busy)
  );

  assign div_sel_o     = ctrl[1:0];
  assign dither_amt_o  = ctrl[3:2];
  assign phase_mode_o  = ctrl[5:4];
  assign dither_rate_o = ctrl[7:6];
  assign dev_addr_o    = dev[DEV_W-1:0];
  assign defer_o       = dev[ADR_W-1];
endmodule

// File: rtl/clkcfg_i2c_slave_chk.sv
module clkcfg_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       nv_busy,
  input logic       addr_ack,
  input logic [3:0] osc_code,
  input logic [1:0] phase_mode
);
  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_busy_noack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |-> !addr_ack);

  p_osc_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    osc_code <= 4'd10);

  p_phase_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_mode != 2'b11);
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_w_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe(sda_oe), .nv_busy(nv_busy), .addr_ack(addr_ack),
  .osc_code(osc_code_o), .phase_mode(phase_mode_o)
);

// File: tb/clkcfg_i2c_slave_test.sv
module clkcfg_i2c_slave_test;
  localparam int Q  = 10;
  localparam int WD = 190000;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, defer;
  logic [1:0] div_sel, amt, phase, rate;
  logic [3:0] osc;
  logic [2:0] dev;
  wire  sda_line = m_sda & ~sda_oe;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  clkcfg_i2c_slave #(.SYNC_STAGES(2), .NV_BUSY_CYCLES(2000)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .div_sel_o(div_sel), .dither_amt_o(amt),
    .phase_mode_o(phase), .dither_rate_o(rate), .osc_code_o(osc),
    .dev_addr_o(dev), .defer_o(defer)
  );

  // register, write data, expected readback
  localparam logic [23:0] VEC [0:7] = '{
    24'h0805F5,   // R2 legal code
    24'h080AFA,   // R2 top legal code
    24'h080BFA,   // R5 reserved code rejected
    24'h08F3F3,   // R2 upper nibble ignored
    24'h024C4C,   // R2 full byte
    24'h02314C,   // R5 phase 11 rejected
    24'h02A7A7,   // R11 field pattern
    24'h0512FF    // R2 unmapped
  };

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_line; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(nack);
  endtask

  task automatic open_dev(input logic [7:0] a);
    bit ok, ack;
    ok = 1'b0;
    for (int i = 0; i < 40 && !ok; i++) begin
      bus_start();
      write_byte(a, ack);
      if (ack) ok = 1'b1;
      else bus_stop();
    end
    check(ok, "R7 address poll", {7'd0, ok}, 8'd1);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] r, input logic [7:0] d);
    bit ack;
    open_dev(a);
    write_byte(r, ack);
    write_byte(d, ack);
    bus_stop();
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [7:0] r, output logic [7:0] d);
    bit ack;
    open_dev(a);
    write_byte(r, ack);
    bus_start();
    write_byte(a | 8'h01, ack);
    read_byte(d, 1'b1);
    bus_stop();
  endtask

  task automatic try_addr(input logic [7:0] a, output bit ack);
    bus_start();
    write_byte(a, ack);
    bus_stop();
  endtask

  task automatic pulse_rst();
    @(negedge clk) rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    bit ack;
    repeat (5) @(negedge clk);
    por_n = 1'b1;
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R10 R11: factory state on the ports
    check({rate, phase, amt, div_sel} == 8'hCD, "R10 R11 reset ctrl fields", {rate, phase, amt, div_sel}, 8'hCD);
    check(osc == 4'd0 && dev == 3'd0 && defer == 1'b0, "R10 reset osc/dev", {osc, defer, dev}, 8'h00);
    check(sda_oe == 1'b0, "R9 idle release", {7'd0, sda_oe}, 8'h00);
    reg_read(8'hB0, 8'h02, rd);
    check(rd == 8'hCD, "R3 read ctrl default", rd, 8'hCD);
    reg_read(8'hB0, 8'h0D, rd);
    check(rd == 8'hF0, "R2 dev reads upper ones", rd, 8'hF0);

    // R1: foreign addresses
    try_addr(8'hB2, ack);
    check(!ack, "R1 wrong low bits nack", {7'd0, ack}, 8'h00);
    try_addr(8'hA0, ack);
    check(!ack, "R1 wrong high bits nack", {7'd0, ack}, 8'h00);

    // R2 R5 R11 table walk
    for (int i = 0; i < 8; i++) begin
      reg_write(8'hB0, VEC[i][23:16], VEC[i][15:8]);
      reg_read(8'hB0, VEC[i][23:16], rd);
      check(rd == VEC[i][7:0], "R2 R5 table readback", rd, VEC[i][7:0]);
    end
    check({rate, phase, amt, div_sel} == 8'hA7, "R11 field mapping", {rate, phase, amt, div_sel}, 8'hA7);
    check(osc == 4'd3, "R5 osc port after table", {4'd0, osc}, 8'h03);

    // R7: busy after write-through
    reg_write(8'hB0, 8'h08, 8'h09);
    try_addr(8'hB0, ack);
    check(!ack, "R7 busy nack", {7'd0, ack}, 8'h00);

    // R4 R10: write-through survives warm reset
    pulse_rst();
    check(osc == 4'd9, "R4 R10 write-through kept", {4'd0, osc}, 8'h09);

    // R4 R6: deferred commit
    reg_write(8'hB0, 8'h0D, 8'h08);
    check(defer == 1'b1, "R4 defer flag set", {7'd0, defer}, 8'h01);
    reg_write(8'hB0, 8'h08, 8'h07);
    try_addr(8'hB0, ack);
    check(ack, "R4 deferred write leaves bus free", {7'd0, ack}, 8'h01);
    check(osc == 4'd7, "R4 working copy updated", {4'd0, osc}, 8'h07);
    pulse_rst();
    check(osc == 4'd9, "R4 deferred not stored", {4'd0, osc}, 8'h09);
    check(defer == 1'b1, "R6 dev register committed", {7'd0, defer}, 8'h01);
    reg_write(8'hB0, 8'h08, 8'h04);
    open_dev(8'hB0);
    write_byte(8'h3F, ack);
    bus_stop();
    try_addr(8'hB0, ack);
    check(!ack, "R4 R7 commit busy nack", {7'd0, ack}, 8'h00);
    pulse_rst();
    check(osc == 4'd4, "R4 commit stored", {4'd0, osc}, 8'h04);

    // R1 R6: new device address
    reg_write(8'hB0, 8'h0D, 8'h05);
    check(dev == 3'd5 && defer == 1'b0, "R6 dev port", {defer, 4'd0, dev}, 8'h05);
    reg_read(8'hBA, 8'h08, rd);
    check(rd == 8'hF4, "R1 read at new address", rd, 8'hF4);
    try_addr(8'hB0, ack);
    check(!ack, "R1 old address nack", {7'd0, ack}, 8'h00);
    reg_write(8'hBA, 8'h0D, 8'h00);

    // R9: START in the middle of a byte
    open_dev(8'hB0);
    bus_stop();
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    write_byte(8'hB0, ack);
    check(ack, "R9 restart address ack", {7'd0, ack}, 8'h01);
    write_byte(8'h08, ack);
    bus_start();
    write_byte(8'hB1, ack);
    read_byte(rd, 1'b1);
    bus_stop();
    check(rd == 8'hF4, "R3 R9 read after restart", rd, 8'hF4);
    check(sda_oe == 1'b0, "R9 release after stop", {7'd0, sda_oe}, 8'h00);

    // R10: power-on restores factory values
    @(negedge clk) begin por_n = 1'b0; rst_n = 1'b0; end
    repeat (4) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(osc == 4'd0 && {rate, phase, amt, div_sel} == 8'hCD, "R10 power-on defaults",
          {rate, phase, amt, div_sel}, 8'hCD);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule